// File: doc/BRIEF.md
# FIFO Watermark Interrupt Controller

This block collects interrupt causes for a message controller that has a transmit queue, a receive queue and a single high-priority transmit slot. The protocol engine sends event levels or pulses, and the queues send their occupancy counts. A 0-to-1 change of any cause latches a sticky status bit. Software removes latched bits by writing ones to a clear register. The block drives one interrupt line, which is high whenever a latched bit has its enable bit set.

Two programmable thresholds turn queue occupancy into events. A receive watermark event fires once the receive count climbs above its threshold. A transmit watermark event fires once the transmit count drops to or below its threshold. A transmit-empty event fires when the transmit count reaches zero.

The receive-not-empty bit is not latched. It always shows whether the receive queue holds any frame, so software can poll it.

Top module: `irq_wm_ctrl`

## Requirements
- R1: After reset the latched status, the enable mask and both thresholds are zero, and the interrupt line is low. A cause that is already true on the first clock edge after reset counts as a rising edge and is latched on that edge.
- R2: The status, enable and clear registers share one bit layout:
  - 0 arbitration lost
  - 1 transmit done
  - 2 transmit queue full
  - 3 priority slot full
  - 4 frame received
  - 5 receive underflow
  - 6 receive overflow
  - 7 receive not empty
  - 8 error
  - 9 bus off
  - 10 sleep
  - 11 wake-up
  - 12 receive watermark
  - 13 transmit watermark
  - 14 transmit empty
  
  Bit i of the protocol event input feeds status bit i for i in 0..11, except bit 7.
- R3: A status bit is set on the clock edge where its cause goes from low to high. The bit then stays set. A cause that is held high sets its bit only once.
- R4: Writing a 1 to a bit of the clear register (offset 0x24) clears that status bit. Writing a 0 leaves the bit unchanged. Reading the clear register returns zero.
- R5: If a bit's cause rises in the same cycle as a clear of that bit, the bit stays set.
- R6: The interrupt line is high exactly when some status bit and its enable bit are both 1. The line follows the status and enable registers with no added delay.
- R7: Status bit 7 always equals (receive count != 0). Bit 7 of the protocol event input is ignored, and clearing bit 7 has no effect.
- R8: Bit 12 is set when (receive count > receive threshold) becomes true.
- R9: Bit 13 is set when (transmit count <= transmit threshold) becomes true.
- R10: Bit 14 is set when (transmit count == 0) becomes true.
- R11: The watermark register (offset 0x2C) holds the receive threshold in bits 5:0 and the transmit threshold in bits 13:8. Its other bits read as zero. The enable register (offset 0x20) keeps bits 14:0, and its upper bits read as zero.
- R12: Read data appears on the clock edge that samples the read strobe and then holds. Status is at offset 0x1C. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| proto_evt_i | input | 12 | Protocol engine causes, bit i to status bit i (bit 7 unused) |
| rx_level_i | input | 7 | Receive queue occupancy, 0 to 64 |
| tx_level_i | input | 7 | Transmit queue occupancy, 0 to 64 |
| irq_o | output | 1 | Interrupt request |

## Verification
A cause driven in cycle k appears in status, and on the interrupt line, right after the edge that ends cycle k. A read strobe in cycle k returns data right after the same edge. The bench drives every input on a falling edge and samples on the following falling edge, one full edge later, so no check races the edge. The watermark sweeps step the occupancy by one per read. The expected bits are computed from the thresholds, including the boundary counts 0, 63 and 64.

// File: rtl/irqw_pkg.sv
package irqw_pkg;
    localparam int SRC_N   = 15;
    localparam int PROTO_N = 12;

    localparam int B_RXNE  = 7;
    localparam int B_RXWM  = 12;
    localparam int B_TXWM  = 13;
    localparam int B_TXEMP = 14;

    localparam int OFS_STAT = 'h1C;
    localparam int OFS_EN   = 'h20;
    localparam int OFS_CLR  = 'h24;
    localparam int OFS_WM   = 'h2C;

    localparam int TX_THR_LSB = 8;

    localparam logic [SRC_N-1:0] LIVE_MASK = SRC_N'(1) << B_RXNE;
endpackage

// File: rtl/irqw_rise_det.sv
module irqw_rise_det #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_q;

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) prev_q[i] <= 1'b0;
                else        prev_q[i] <= lvl_i[i];
            end
            assign rise_o[i] = lvl_i[i] & ~prev_q[i];
        end
    endgenerate
endmodule

// File: rtl/irqw_wmark_cmp.sv
module irqw_wmark_cmp #(
    parameter int CNT_W = 7,
    parameter int THR_W = 6
) (
    input  logic [CNT_W-1:0] rx_lvl_i,
    input  logic [CNT_W-1:0] tx_lvl_i,
    input  logic [THR_W-1:0] rx_thr_i,
    input  logic [THR_W-1:0] tx_thr_i,
    output logic             rx_above_o,
    output logic             tx_low_o,
    output logic             tx_empty_o,
    output logic             rx_nempty_o
);
    logic [CNT_W-1:0] rx_thr_ext;
    logic [CNT_W-1:0] tx_thr_ext;

    assign rx_thr_ext  = CNT_W'(rx_thr_i);
    assign tx_thr_ext  = CNT_W'(tx_thr_i);
    assign rx_above_o  = rx_lvl_i > rx_thr_ext;
    assign tx_low_o    = tx_lvl_i <= tx_thr_ext;
    assign tx_empty_o  = tx_lvl_i == '0;
    assign rx_nempty_o = rx_lvl_i != '0;
endmodule

// File: rtl/irqw_status_bank.sv
module irqw_status_bank #(
    parameter int           W    = 15,
    parameter logic [W-1:0] LIVE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    input  logic [W-1:0] live_i,
    output logic [W-1:0] stat_o
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            if (LIVE[i]) begin : g_live
                logic unused_ctl;
                assign unused_ctl = set_i[i] ^ clr_i[i];
                assign stat_o[i]  = live_i[i];
            end else begin : g_sticky
                logic q;
                logic unused_live;
                assign unused_live = live_i[i];
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) q <= 1'b0;
                    else        q <= set_i[i] | (q & ~clr_i[i]);
                end
                assign stat_o[i] = q;
            end
        end
    endgenerate
endmodule

// File: rtl/irqw_regfile.sv
module irqw_regfile #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int W      = 15,
    parameter int THR_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [W-1:0]      stat_i,
    output logic [W-1:0]      en_o,
    output logic [W-1:0]      clr_o,
    output logic [THR_W-1:0]  rx_thr_o,
    output logic [THR_W-1:0]  tx_thr_o,
    output logic [DATA_W-1:0] rdata_o
);
    import irqw_pkg::*;

    logic              hit_stat, hit_en, hit_clr, hit_wm;
    logic [W-1:0]      en_q;
    logic [THR_W-1:0]  rx_thr_q, tx_thr_q;
    logic [DATA_W-1:0] rd_next, rdata_q;
    logic              unused_wdata;

    assign hit_stat = addr_i == ADDR_W'(OFS_STAT);
    assign hit_en   = addr_i == ADDR_W'(OFS_EN);
    assign hit_clr  = addr_i == ADDR_W'(OFS_CLR);
    assign hit_wm   = addr_i == ADDR_W'(OFS_WM);

    assign unused_wdata = ^wdata_i[DATA_W-1:W] ^ hit_clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= '0;
            rx_thr_q <= '0;
            tx_thr_q <= '0;
        end else if (wr_i) begin
            if (hit_en) en_q <= wdata_i[W-1:0];
            if (hit_wm) begin
                rx_thr_q <= wdata_i[THR_W-1:0];
                tx_thr_q <= wdata_i[TX_THR_LSB +: THR_W];
            end
        end
    end

    assign clr_o = (wr_i && hit_clr) ? wdata_i[W-1:0] : '0;

    always_comb begin
        rd_next = '0;
        if (hit_stat) begin
            rd_next[W-1:0] = stat_i;
        end else if (hit_en) begin
            rd_next[W-1:0] = en_q;
        end else if (hit_wm) begin
            rd_next[THR_W-1:0]              = rx_thr_q;
            rd_next[TX_THR_LSB +: THR_W]    = tx_thr_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    rdata_q <= '0;
        else if (rd_i) rdata_q <= rd_next;
    end

    assign en_o     = en_q;
    assign rx_thr_o = rx_thr_q;
    assign tx_thr_o = tx_thr_q;
    assign rdata_o  = rdata_q;
endmodule

// File: rtl/irq_wm_ctrl.sv
module irq_wm_ctrl #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int FIFO_DEPTH = 64,
    parameter int THR_W      = 6
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             reg_wr_i,
    input  logic                             reg_rd_i,
    input  logic [ADDR_W-1:0]                reg_addr_i,
    input  logic [DATA_W-1:0]                reg_wdata_i,
    output logic [DATA_W-1:0]                reg_rdata_o,
    input  logic [irqw_pkg::PROTO_N-1:0]     proto_evt_i,
    input  logic [$clog2(FIFO_DEPTH+1)-1:0]  rx_level_i,
    input  logic [$clog2(FIFO_DEPTH+1)-1:0]  tx_level_i,
    output logic                             irq_o
);
    import irqw_pkg::*;

    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    logic [SRC_N-1:0] src_lvl, src_rise, stat_vec, en_vec, clr_vec, live_vec;
    logic [THR_W-1:0] rx_thr, tx_thr;
    logic             rx_above, tx_low, tx_empty, rx_nempty;

    irqw_wmark_cmp #(.CNT_W(CNT_W), .THR_W(THR_W)) u_cmp (
        .rx_lvl_i    (rx_level_i),
        .tx_lvl_i    (tx_level_i),
        .rx_thr_i    (rx_thr),
        .tx_thr_i    (tx_thr),
        .rx_above_o  (rx_above),
        .tx_low_o    (tx_low),
        .tx_empty_o  (tx_empty),
        .rx_nempty_o (rx_nempty)
    );

    assign src_lvl[PROTO_N-1:0] = proto_evt_i;
    assign src_lvl[B_RXWM]      = rx_above;
    assign src_lvl[B_TXWM]      = tx_low;
    assign src_lvl[B_TXEMP]     = tx_empty;

    assign live_vec = SRC_N'(rx_nempty) << B_RXNE;

    irqw_rise_det #(.W(SRC_N)) u_rise (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (src_lvl),
        .rise_o (src_rise)
    );

    irqw_status_bank #(.W(SRC_N), .LIVE(LIVE_MASK)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (src_rise),
        .clr_i  (clr_vec),
        .live_i (live_vec),
        .stat_o (stat_vec)
    );

    irqw_regfile #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .W      (SRC_N),
        .THR_W  (THR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (reg_wr_i),
        .rd_i     (reg_rd_i),
        .addr_i   (reg_addr_i),
        .wdata_i  (reg_wdata_i),
        .stat_i   (stat_vec),
        .en_o     (en_vec),
        .clr_o    (clr_vec),
        .rx_thr_o (rx_thr),
        .tx_thr_o (tx_thr),
        .rdata_o  (reg_rdata_o)
    );

    assign irq_o = |(stat_vec & en_vec);
endmodule

// File: rtl/irqw_checker.sv
module irqw_checker #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 7,
    parameter int W      = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_i,
    input logic              reg_rd_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic [DATA_W-1:0] reg_wdata_i,
    input logic [DATA_W-1:0] reg_rdata_o,
    input logic [CNT_W-1:0]  rx_level_i,
    input logic              irq_o,
    input logic [W-1:0]      src_rise,
    input logic [W-1:0]      stat_vec,
    input logic [W-1:0]      en_vec
);
    import irqw_pkg::*;

    logic clr_wr, en_wr;
    assign clr_wr = reg_wr_i && (reg_addr_i == ADDR_W'(OFS_CLR));
    assign en_wr  = reg_wr_i && (reg_addr_i == ADDR_W'(OFS_EN));

    AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        src_rise[0] |=> stat_vec[0]); // R3
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_rise[0] && !(clr_wr && reg_wdata_i[0])) |=> stat_vec[0] == $past(stat_vec[0])); // R3
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && reg_wdata_i[0] && !src_rise[0]) |=> !stat_vec[0]); // R4
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && reg_wdata_i[1] && src_rise[1]) |=> stat_vec[1]); // R5
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (en_vec == '0) |-> !irq_o); // R6
    AST_ENABLED_RISE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (src_rise[2] && en_vec[2] && !en_wr) |=> irq_o); // R6
    AST_RXNE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_i && reg_addr_i == ADDR_W'(OFS_STAT)) |=> reg_rdata_o[B_RXNE] == $past(rx_level_i != '0)); // R7
    AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_i && reg_addr_i == ADDR_W'(OFS_CLR)) |=> reg_rdata_o == '0); // R4
    AST_WM_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_i && reg_addr_i == ADDR_W'(OFS_WM)) |=> (reg_rdata_o[DATA_W-1:14] == '0 && reg_rdata_o[7:6] == 2'b00)); // R11
endmodule

bind irq_wm_ctrl irqw_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .W      (irqw_pkg::SRC_N)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_i    (reg_wr_i),
    .reg_rd_i    (reg_rd_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .rx_level_i  (rx_level_i),
    .irq_o       (irq_o),
    .src_rise    (src_rise),
    .stat_vec    (stat_vec),
    .en_vec      (en_vec)
);

// File: tb/irq_wm_ctrl_tb.sv
`timescale 1ns/1ps
module irq_wm_ctrl_tb;
    localparam logic [7:0] A_STAT = 8'h1C;
    localparam logic [7:0] A_EN   = 8'h20;
    localparam logic [7:0] A_CLR  = 8'h24;
    localparam logic [7:0] A_WM   = 8'h2C;
    localparam logic [7:0] A_NONE = 8'h30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [11:0] proto = '0;
    logic [6:0]  rx_lvl = '0, tx_lvl = '0;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    irq_wm_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_i    (reg_wr),
        .reg_rd_i    (reg_rd),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .proto_evt_i (proto),
        .rx_level_i  (rx_lvl),
        .tx_level_i  (tx_lvl),
        .irq_o       (irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic pulse(input int b);
        @(negedge clk);
        proto[b] = 1'b1;
        @(negedge clk);
        proto[b] = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 irq after reset", {31'b0, irq}, 32'h0);
        rd(A_STAT, d);
        check("R1 first-edge tx causes latched", d, 32'h0000_6000);
        check("R1 irq low with mask zero", {31'b0, irq}, 32'h0);
        rd(A_EN, d);
        check("R1 enable reset", d, 32'h0);
        rd(A_WM, d);
        check("R1 watermark reset", d, 32'h0);
        rd(A_CLR, d);
        check("R4 clear reads zero", d, 32'h0);
        rd(A_NONE, d);
        check("R12 unmapped reads zero", d, 32'h0);
        wr(A_CLR, 32'h7FFF);
        rd(A_STAT, d);
        check("R4 clear all", d, 32'h0);
        wr(A_EN, 32'hFFFF_FFFF);
        rd(A_EN, d);
        check("R11 enable width", d, 32'h0000_7FFF);

        for (int b = 0; b < 12; b++) begin
            if (b == 7) begin
                pulse(7);
                rd(A_STAT, d);
                check("R7 input bit 7 ignored", d, 32'h0);
                continue;
            end
            wr(A_EN, 32'h7FFF & ~(32'h1 << b));
            pulse(b);
            check("R6 masked source keeps irq low", {31'b0, irq}, 32'h0);
            rd(A_STAT, d);
            check("R2 R3 source position", d, 32'h1 << b);
            wr(A_CLR, 32'h0);
            rd(A_STAT, d);
            check("R4 zero write no effect", d, 32'h1 << b);
            wr(A_EN, 32'h1 << b);
            check("R6 enabled bit raises irq", {31'b0, irq}, 32'h1);
            wr(A_CLR, 32'h7FFF & ~(32'h1 << b));
            rd(A_STAT, d);
            check("R4 other clear bits no effect", d, 32'h1 << b);
            wr(A_CLR, 32'h1 << b);
            check("R6 irq drops after clear", {31'b0, irq}, 32'h0);
            rd(A_STAT, d);
            check("R4 clear own bit", d, 32'h0);
        end

        // R3: a held cause latches only once
        @(negedge clk); proto[0] = 1'b1;
        repeat (2) @(negedge clk);
        wr(A_CLR, 32'h1);
        rd(A_STAT, d);
        check("R3 held cause does not re-set", d, 32'h0);
        @(negedge clk); proto[0] = 1'b0;
        rd(A_STAT, d);
        check("R3 fall does not set", d, 32'h0);

        // R5: rise and clear in the same cycle
        @(negedge clk);
        proto[1] = 1'b1; reg_wr = 1'b1; reg_addr = A_CLR; reg_wdata = 32'h2;
        @(negedge clk);
        proto[1] = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        rd(A_STAT, d);
        check("R5 event beats clear", d, 32'h2);
        wr(A_CLR, 32'h2);

        // R7: clearing the live bit has no effect
        @(negedge clk); rx_lvl = 7'd3;
        wr(A_CLR, 32'h80);
        rd(A_STAT, d);
        check("R7 live bit survives clear", d & 32'h80, 32'h80);
        @(negedge clk); rx_lvl = 7'd0;
        wr(A_CLR, 32'h7FFF);

        wr(A_WM, 32'hFFFF_FFFF);
        rd(A_WM, d);
        check("R11 watermark layout", d, 32'h0000_3F3F);

        // R8 sweep over receive thresholds
        wr(A_EN, 32'h1 << 12);
        for (int t = 0; t < 4; t++) begin
            int thr;
            thr = (t == 0) ? 0 : (t == 1) ? 5 : (t == 2) ? 31 : 63;
            @(negedge clk); rx_lvl = 7'd0;
            wr(A_WM, 32'(thr));
            wr(A_CLR, 32'h7FFF);
            for (int c = 0; c <= 64; c++) begin
                @(negedge clk); rx_lvl = 7'(c);
                rd(A_STAT, d);
                exp = ((c > thr) ? 32'h1000 : 32'h0) | ((c != 0) ? 32'h80 : 32'h0);
                check("R8 R7 receive watermark sweep", d, exp);
                check("R6 receive watermark irq", {31'b0, irq}, (c > thr) ? 32'h1 : 32'h0);
            end
        end
        @(negedge clk); rx_lvl = 7'd0;
        wr(A_EN, 32'h0);

        // R9 R10 sweep over transmit thresholds
        for (int t = 0; t < 3; t++) begin
            int thr;
            thr = (t == 0) ? 0 : (t == 1) ? 7 : 63;
            @(negedge clk); tx_lvl = 7'd64;
            wr(A_WM, 32'(thr) << 8);
            wr(A_CLR, 32'h7FFF);
            for (int c = 64; c >= 0; c--) begin
                @(negedge clk); tx_lvl = 7'(c);
                rd(A_STAT, d);
                exp = ((c <= thr) ? 32'h2000 : 32'h0) | ((c == 0) ? 32'h4000 : 32'h0);
                check("R9 R10 transmit watermark sweep", d, exp);
            end
        end

        if (!finished) begin
            finished = 1'b1;
            summary();
        end
    end
endmodule